// File: doc/BRIEF.md
# Microinstruction ALU Control and Condition Decoder

This block turns the upper control byte of a microinstruction into the control lines of a small 8-bit ALU. Five compressed control bits are expanded into two 4-bit function codes (one for an upper logic unit, one for a lower logic unit), the adder carry-in, a shift-right enable with its fill bit, and the source of the carry result. The remaining three bits of the byte pick one of eight conditions. That condition either feeds a carry-in or is written into a conditional-execution flag F.

The block also holds the processor flags N, Z and C, a temporary carry TC used for multi-byte arithmetic, and F. The adder, the logic units and the microcode store are outside the block. The adder carry-out, the ALU result byte and the data bus reach it as inputs. A separate active-low ALT line turns selected control patterns into special cases: shift-right, RES/XOR, SUB and DEC.

Top module: `alu_ucode_ctl`

## Requirements
- R1: After reset, the flags N, Z, C, TC and F are all 0.
- R2: The lower function code is 0101 when control bits 3..1 equal 6 and ALT is asserted (alt_n = 0), which is the SUB case. In all other cases it is 1010 when control bit 0 is 1 and 0000 when it is 0.
- R3: In group 1 (control bit 3 = 1), the upper function code {D,C,B,A} is {bit4, bit2, bit1, A}. A is 1 only for DEC, which is control bits 3..1 = 7 with alt_n = 0.
- R4: In group 0 (control bit 3 = 0), the upper function code is 0000. The exception is control bits 3..1 = 1 with alt_n = 0, which gives 0010 (RES) when bit 4 is 0 and 0110 (XOR) when bit 4 is 1.
- R5: Shift-right enable is 1 only for control bits 3..1 = 0 with alt_n = 0. The shift-right fill bit equals the selected condition in group 0 and is 0 in group 1.
- R6: The adder carry-in equals the selected condition in group 1 and is 0 in group 0.
- R7: The carry result equals the adder carry-out in group 1 and equals data bus bit 0 in group 0.
- R8: At each clock edge, TC loads the adder carry-out in group 1 and keeps its value in group 0.
- R9: At a clock edge, N loads result bit 7 when upd_n is 1, Z loads 1 if the result is zero when upd_z is 1, and C loads the carry result when upd_c is 1. A flag whose update bit is 0 keeps its value.
- R10: Condition select (byte bits 7..5) codes 0..7 give constant 0, constant 1, C, TC, N, Z, data bit 0 and data bit 7. Flags are read as they stand before the clock edge.
- R11: At a clock edge, F loads the selected condition when wr_f is 1 and keeps its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uc_hi | input | 8 | Upper microinstruction byte: bits 4..0 ALU control, bits 7..5 condition select |
| alt_n | input | 1 | Special-case enable, active low |
| add_cout | input | 1 | Carry-out of the external adder |
| dbus | input | 8 | Data bus (bit 0 and bit 7 used) |
| res | input | 8 | ALU result byte |
| upd_n | input | 1 | Update enable for N |
| upd_z | input | 1 | Update enable for Z |
| upd_c | input | 1 | Update enable for C |
| wr_f | input | 1 | Write enable for F |
| up_fn | output | 4 | Upper logic unit function {D,C,B,A} |
| lo_fn | output | 4 | Lower logic unit function {D,C,B,A} |
| add_cin | output | 1 | Adder carry-in |
| shr_en | output | 1 | Shift-right unit enable |
| shr_cin | output | 1 | Shift-right fill bit |
| carry_res | output | 1 | ALU carry result |
| cond | output | 1 | Selected condition |
| flg_n | output | 1 | N flag |
| flg_z | output | 1 | Z flag |
| flg_c | output | 1 | C flag |
| flg_tc | output | 1 | Temporary carry |
| flg_f | output | 1 | Conditional-execution flag |

## Verification
The interesting collision is an instruction whose condition select reads C or TC while the same instruction rewrites that flag. For example, a group-1 add selects C as its carry-in with upd_c set, or wr_f copies TC while a group-1 operation reloads TC. The bench sets up such cycles on purpose, and random vectors also produce them. In each case it checks that add_cin, shr_cin and cond reflect the flag value from before the edge, and that the flag afterwards holds the newly computed value.

// File: rtl/alu_uc_pkg.sv
package alu_uc_pkg;
    localparam int ALU_BITS = 5;
    localparam int SEL_BITS = 3;
    localparam int NCOND    = 1 << SEL_BITS;
    localparam int FN_W     = 4;
    localparam int NSPEC    = 1 << (ALU_BITS - 2);

    typedef enum logic [SEL_BITS-1:0] {
        CND_ZERO = 3'd0,
        CND_ONE  = 3'd1,
        CND_C    = 3'd2,
        CND_TC   = 3'd3,
        CND_N    = 3'd4,
        CND_Z    = 3'd5,
        CND_D0   = 3'd6,
        CND_D7   = 3'd7
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic tc;
        logic f;
    } flags_t;

    localparam int SP_SHR  = 0;
    localparam int SP_RXOR = 1;
    localparam int SP_SUB  = 6;
    localparam int SP_DEC  = 7;

    localparam logic [FN_W-1:0] LO_PASS = 4'b0000;
    localparam logic [FN_W-1:0] LO_ALT  = 4'b1010;
    localparam logic [FN_W-1:0] LO_SUB  = 4'b0101;
endpackage

// File: rtl/alu_fn_decode.sv
module alu_fn_decode
    import alu_uc_pkg::*;
(
    input  logic [ALU_BITS-1:0] alu_ctl,
    input  logic                alt_n,
    input  logic                cond,
    input  logic                add_cout,
    input  logic                d0,
    output logic [FN_W-1:0]     up_fn,
    output logic [FN_W-1:0]     lo_fn,
    output logic                add_cin,
    output logic                shr_en,
    output logic                shr_cin,
    output logic                carry_res,
    output logic                group1
);
    localparam int IDX_W = ALU_BITS - 2;

    logic [IDX_W-1:0] idx;
    logic [NSPEC-1:0] spec;

    assign idx    = alu_ctl[IDX_W:1];
    assign group1 = alu_ctl[IDX_W];

    // one line per special case, live only while ALT is asserted
    for (genvar i = 0; i < NSPEC; i++) begin : g_spec
        assign spec[i] = !alt_n && (idx == IDX_W'(i));
    end

    always_comb begin
        if (group1) begin
            up_fn = {alu_ctl[4], alu_ctl[2], alu_ctl[1], spec[SP_DEC]};
        end else begin
            up_fn = {1'b0, spec[SP_RXOR] & alu_ctl[4], spec[SP_RXOR], 1'b0};
        end
    end

    always_comb begin
        if (spec[SP_SUB])      lo_fn = LO_SUB;
        else if (alu_ctl[0])   lo_fn = LO_ALT;
        else                   lo_fn = LO_PASS;
    end

    assign add_cin   = group1 ? cond : 1'b0;
    assign shr_en    = spec[SP_SHR];
    assign shr_cin   = group1 ? 1'b0 : cond;
    assign carry_res = group1 ? add_cout : d0;
endmodule

// File: rtl/cond_select.sv
module cond_select
    import alu_uc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [SEL_BITS-1:0] sel,
    input  flags_t              flg,
    input  logic [DW-1:0]       dbus,
    output logic                cond
);
    cond_e code;
    assign code = cond_e'(sel);

    always_comb begin
        unique case (code)
            CND_ZERO: cond = 1'b0;
            CND_ONE:  cond = 1'b1;
            CND_C:    cond = flg.c;
            CND_TC:   cond = flg.tc;
            CND_N:    cond = flg.n;
            CND_Z:    cond = flg.z;
            CND_D0:   cond = dbus[0];
            CND_D7:   cond = dbus[DW-1];
            default:  cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/flag_regs.sv
module flag_regs
    import alu_uc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_n,
    input  logic          upd_z,
    input  logic          upd_c,
    input  logic          wr_f,
    input  logic          group1,
    input  logic          add_cout,
    input  logic          carry_res,
    input  logic [DW-1:0] res,
    input  logic          cond,
    output flags_t        q
);
    flags_t d;

    always_comb begin
        d    = q;
        if (upd_n)  d.n  = res[DW-1];
        if (upd_z)  d.z  = ~|res;
        if (upd_c)  d.c  = carry_res;
        if (group1) d.tc = add_cout;
        if (wr_f)   d.f  = cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9
    n_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_n |=> $stable(q.n));
    // R9
    c_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_c |=> (q.c == $past(carry_res)));
    // R8
    tc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !group1 |=> $stable(q.tc));
    // R11
    f_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_f |=> (q.f == $past(cond)));
endmodule

// File: rtl/alu_ucode_ctl.sv
module alu_ucode_ctl
    import alu_uc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    uc_hi,
    input  logic          alt_n,
    input  logic          add_cout,
    input  logic [DW-1:0] dbus,
    input  logic [DW-1:0] res,
    input  logic          upd_n,
    input  logic          upd_z,
    input  logic          upd_c,
    input  logic          wr_f,
    output logic [3:0]    up_fn,
    output logic [3:0]    lo_fn,
    output logic          add_cin,
    output logic          shr_en,
    output logic          shr_cin,
    output logic          carry_res,
    output logic          cond,
    output logic          flg_n,
    output logic          flg_z,
    output logic          flg_c,
    output logic          flg_tc,
    output logic          flg_f
);
    flags_t flg;
    logic   group1;

    cond_select #(.DW(DW)) u_cond (
        .sel  (uc_hi[ALU_BITS +: SEL_BITS]),
        .flg  (flg),
        .dbus (dbus),
        .cond (cond)
    );

    alu_fn_decode u_dec (
        .alu_ctl   (uc_hi[ALU_BITS-1:0]),
        .alt_n     (alt_n),
        .cond      (cond),
        .add_cout  (add_cout),
        .d0        (dbus[0]),
        .up_fn     (up_fn),
        .lo_fn     (lo_fn),
        .add_cin   (add_cin),
        .shr_en    (shr_en),
        .shr_cin   (shr_cin),
        .carry_res (carry_res),
        .group1    (group1)
    );

    flag_regs #(.DW(DW)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_n     (upd_n),
        .upd_z     (upd_z),
        .upd_c     (upd_c),
        .wr_f      (wr_f),
        .group1    (group1),
        .add_cout  (add_cout),
        .carry_res (carry_res),
        .res       (res),
        .cond      (cond),
        .q         (flg)
    );

    assign flg_n  = flg.n;
    assign flg_z  = flg.z;
    assign flg_c  = flg.c;
    assign flg_tc = flg.tc;
    assign flg_f  = flg.f;

    // R6
    cin_g0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uc_hi[3] |-> !add_cin);
    // R5
    shr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shr_en |-> (uc_hi[3:1] == 3'd0 && !alt_n));
    // R2
    sub_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_fn == 4'b0101) |-> (uc_hi[3:1] == 3'd6 && !alt_n));
endmodule

// File: tb/test_alu_ucode_ctl.sv
module test_alu_ucode_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 1500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] uc_hi = '0;
    logic       alt_n = 1'b1;
    logic       add_cout = 1'b0;
    logic [7:0] dbus = '0;
    logic [7:0] res = '0;
    logic       upd_n = 1'b0, upd_z = 1'b0, upd_c = 1'b0, wr_f = 1'b0;
    logic [3:0] up_fn, lo_fn;
    logic       add_cin, shr_en, shr_cin, carry_res, cond;
    logic       flg_n, flg_z, flg_c, flg_tc, flg_f;

    int n_chk = 0;
    int n_err = 0;
    logic mn = 0, mz = 0, mc = 0, mtc = 0, mf = 0;

    alu_ucode_ctl i_alu_ucode_ctl (
        .clk(clk), .rst_n(rst_n), .uc_hi(uc_hi), .alt_n(alt_n),
        .add_cout(add_cout), .dbus(dbus), .res(res),
        .upd_n(upd_n), .upd_z(upd_z), .upd_c(upd_c), .wr_f(wr_f),
        .up_fn(up_fn), .lo_fn(lo_fn), .add_cin(add_cin), .shr_en(shr_en),
        .shr_cin(shr_cin), .carry_res(carry_res), .cond(cond),
        .flg_n(flg_n), .flg_z(flg_z), .flg_c(flg_c), .flg_tc(flg_tc), .flg_f(flg_f)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h (uc_hi=%h alt_n=%b)", req, act, exp, uc_hi, alt_n);
        end
    endtask

    function automatic logic exp_cond(input logic [2:0] s, input logic [7:0] db);
        case (s)
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd2: return mc;
            3'd3: return mtc;
            3'd4: return mn;
            3'd5: return mz;
            3'd6: return db[0];
            default: return db[7];
        endcase
    endfunction

    function automatic logic [3:0] exp_up(input logic [7:0] u, input logic a_n);
        if (u[3]) return {u[4], u[2], u[1], (u[3:1] == 3'd7) && !a_n};
        if (u[3:1] == 3'd1 && !a_n) return u[4] ? 4'b0110 : 4'b0010;
        return 4'b0000;
    endfunction

    function automatic logic [3:0] exp_lo(input logic [7:0] u, input logic a_n);
        if (u[3:1] == 3'd6 && !a_n) return 4'b0101;
        return u[0] ? 4'b1010 : 4'b0000;
    endfunction

    task automatic step(input logic [7:0] u, input logic a_n, input logic co,
                        input logic [7:0] db, input logic [7:0] rs,
                        input logic un, input logic uz, input logic ucf, input logic wf);
        logic c_e, cr_e, g1;
        @(negedge clk);
        uc_hi = u; alt_n = a_n; add_cout = co; dbus = db; res = rs;
        upd_n = un; upd_z = uz; upd_c = ucf; wr_f = wf;
        #1;
        g1   = u[3];
        c_e  = exp_cond(u[7:5], db);
        cr_e = g1 ? co : db[0];
        chk("R10 cond", {3'b0, cond}, {3'b0, c_e});
        chk("R2 lo_fn", lo_fn, exp_lo(u, a_n));
        chk(g1 ? "R3 up_fn" : "R4 up_fn", up_fn, exp_up(u, a_n));
        chk("R5 shr_en", {3'b0, shr_en}, {3'b0, (u[3:1] == 3'd0) && !a_n});
        chk("R5 shr_cin", {3'b0, shr_cin}, {3'b0, g1 ? 1'b0 : c_e});
        chk("R6 add_cin", {3'b0, add_cin}, {3'b0, g1 ? c_e : 1'b0});
        chk("R7 carry_res", {3'b0, carry_res}, {3'b0, cr_e});
        if (un)  mn  = rs[7];
        if (uz)  mz  = (rs == 8'd0);
        if (ucf) mc  = cr_e;
        if (g1)  mtc = co;
        if (wf)  mf  = c_e;
        @(posedge clk);
        #1;
        chk("R9 flag N", {3'b0, flg_n}, {3'b0, mn});
        chk("R9 flag Z", {3'b0, flg_z}, {3'b0, mz});
        chk("R9 flag C", {3'b0, flg_c}, {3'b0, mc});
        chk("R8 flag TC", {3'b0, flg_tc}, {3'b0, mtc});
        chk("R11 flag F", {3'b0, flg_f}, {3'b0, mf});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 reset flags", {flg_n, flg_z, flg_c, flg_tc}, 4'b0000);
        chk("R1 reset F", {3'b0, flg_f}, 4'b0000);

        // R2 SUB special, R3 DEC special, R4 RES and XOR, R5 shift-right
        step(8'b000_01101, 1'b0, 1'b1, 8'h00, 8'h00, 1, 1, 1, 0); // SUB, Z=1, C=1, TC=1
        step(8'b010_11111, 1'b0, 1'b0, 8'h00, 8'h80, 1, 1, 0, 0); // DEC, cin=C=1
        step(8'b001_00011, 1'b0, 1'b0, 8'h00, 8'h01, 0, 0, 0, 1); // RES, F<=1
        step(8'b011_10011, 1'b0, 1'b1, 8'h01, 8'h01, 0, 0, 1, 1); // XOR, carry from D0, F<=TC
        step(8'b001_00011, 1'b1, 1'b1, 8'h00, 8'h01, 0, 0, 0, 0); // index 1 without ALT: pass
        step(8'b110_00000, 1'b0, 1'b1, 8'h01, 8'h00, 0, 0, 1, 0); // shift-right, fill = D0
        // read C while the same edge rewrites it (R10 before-edge value)
        step(8'b010_01000, 1'b1, 1'b0, 8'h00, 8'h05, 0, 0, 1, 1);
        step(8'b010_01000, 1'b1, 1'b1, 8'h00, 8'h05, 0, 0, 1, 1);
        // read TC while group 1 reloads it (R8 / R10)
        step(8'b011_11000, 1'b1, 1'b0, 8'h00, 8'h00, 0, 0, 0, 1);
        step(8'b011_11000, 1'b1, 1'b1, 8'h80, 8'h00, 0, 0, 0, 1);
        step(8'b111_00100, 1'b1, 1'b0, 8'h80, 8'h00, 0, 0, 0, 1); // D7 select, group 0 TC hold

        for (int i = 0; i < NRAND; i++) begin
            logic [31:0] r;
            logic [31:0] r2;
            r  = $urandom;
            r2 = $urandom;
            step(r[7:0], r[8], r[9], r[17:10],
                 r2[3] ? 8'h00 : r2[11:4],
                 r[18], r[19], r[20], r[21]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule